// File: doc/BRIEF.md
# Character LCD Fixed-Timing Sequencer

This block drives a character LCD module over its 8-bit parallel bus without ever reading the module's busy flag. After reset it waits out a power-on delay. It then issues a fixed initialization program: the function-set byte repeated a configurable number of times, display on with the cursor hidden, increment entry mode, and finally either the slow clear-display command or a quick set-address-to-zero command.

Once initialization is complete it loops forever, rewriting the whole screen. Each line starts with a set-address command, which is followed by that line's characters. The characters are fetched from an external buffer through a combinational index/data port.

Every bus write is one step of fixed length. The step is built from a bus cycle whose length equals the short instruction time, followed by a wait after the command. The timing is derived from the clock frequency and a margin percentage, so the LCD controller's own oscillator may run slow without losing commands.

Top module: `charlcd_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `lcd_e`, `lcd_rs`, `lcd_db` and `init_done` are 0 after that edge. `lcd_rw` is 0 at all times.
- R2: After reset is released, the first rising edge of `lcd_e` comes between PWR and PWR+2 clock cycles later, where PWR = ceil(CLK_HZ*PWRON_US/10^6).
- R3: The initialization writes all have `lcd_rs`=0. They are 0x38 repeated FSET_REPEAT times, then 0x0C, then 0x06, then 0x01 when USE_CLEAR=1.
- R4: With USE_CLEAR=0, the last initialization write is 0x80 instead of 0x01, and its step has the short length.
- R5: Let S = ceil(CLK_HZ*37*MARGIN_PCT/10^8) and L = ceil(CLK_HZ*1520*MARGIN_PCT/10^8). The distance between successive `lcd_e` rising edges is S+L cycles when the earlier write is 0x01, and 2*S cycles otherwise.
- R6: Each `lcd_e` pulse is high for exactly ceil(S/2) cycles. `lcd_rs` and `lcd_db` do not change from the cycle before the pulse rises through the cycle in which it falls.
- R7: `init_done` is 0 during every initialization write. It rises exactly one cycle before the `lcd_e` rise of the first refresh write, and it stays high until reset.
- R8: A refresh pass takes each line n, from 0 to LINES-1, in turn. Line n is written as the command 0x80|base(n), with `lcd_rs`=0, where base(0)=0x00 and base(1)=0x40. That command is followed by COLS character writes with `lcd_rs`=1, carrying the buffer bytes at indices n*COLS+0 through n*COLS+COLS-1, which are presented on `chr_addr`.
- R9: Refresh passes repeat back to back with identical content for an unchanged buffer. No initialization command is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency given by CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| lcd_rs | output | 1 | Register select: 0 command, 1 character |
| lcd_rw | output | 1 | Read/write select, held at 0 (write) |
| lcd_e | output | 1 | Enable strobe |
| lcd_db | output | 8 | Data bus byte |
| chr_addr | output | CHR_AW | Character buffer index |
| chr_data | input | 8 | Character at `chr_addr`, combinational |
| init_done | output | 1 | High once initialization has finished |

## Verification
The bench builds two instances of the block. Both declare a 1 MHz clock to the block, which keeps the 1.52 ms wait to a few thousand cycles.

The first instance uses a 150 % margin, three function-set writes, the clear command, and a 2x16 screen. With these values the fractional delay rounds up (S=56, L=2280), the long step follows the clear command, and two full refresh passes fit within the run.

The second instance uses a 100 % margin, four function-set writes, set-address in place of clear, and a 2x8 screen. It covers the alternative last command with the short wait, an odd bus cycle (S=37, pulse of 19 cycles), and a narrower index port.

// File: rtl/charlcd_pkg.sv
// Package: command bytes, sequencer state type and the helpers that turn
// microsecond figures into clock cycles. Assumes CLK_HZ*us*margin fits in 64 bits.
package charlcd_pkg;

    localparam logic [7:0] CMD_FUNC_8B2L  = 8'h38;
    localparam logic [7:0] CMD_DISP_ON    = 8'h0C;
    localparam logic [7:0] CMD_ENTRY_INC  = 8'h06;
    localparam logic [7:0] CMD_CLEAR      = 8'h01;
    localparam logic [7:0] CMD_SET_ADDR   = 8'h80;

    localparam int SHORT_US = 37;
    localparam int LONG_US  = 1520;

    typedef enum logic [1:0] {
        ST_POWER = 2'd0,
        ST_INIT  = 2'd1,
        ST_RUN   = 2'd2
    } seq_st_t;

    // Cycles covering `us` microseconds scaled by margin_pct percent, rounded up.
    function automatic int scaled_cycles(longint clk_hz, longint us, longint margin_pct);
        return int'((clk_hz * us * margin_pct + 64'd99_999_999) / 64'd100_000_000);
    endfunction

    // Cycles covering `us` microseconds with no margin, at least one.
    function automatic int plain_cycles(longint clk_hz, longint us);
        longint c;
        c = (clk_hz * us + 64'd999_999) / 64'd1_000_000;
        return (c < 1) ? 1 : int'(c);
    endfunction

    // Display RAM address of the first column of a line.
    function automatic logic [6:0] line_base(int line);
        case (line)
            0:       return 7'h00;
            1:       return 7'h40;
            2:       return 7'h14;
            default: return 7'h54;
        endcase
    endfunction

endpackage

// File: rtl/charlcd_init_rom.sv
// Init program store: maps an initialization step number to its command byte
// and tells whether the step needs the long wait. Assumes step < FSET_REPEAT+3.
module charlcd_init_rom
    import charlcd_pkg::*;
#(
    parameter int FSET_REPEAT = 3,
    parameter int USE_CLEAR   = 1,
    parameter int K_W         = 3
) (
    input  logic [K_W-1:0] step,
    output logic [7:0]     code,
    output logic           long_wait
);

    logic [7:0] last_code;
    logic       last_long;

    // Final init command: slow clear or quick address reset.
    generate
        if (USE_CLEAR != 0) begin : g_clear
            assign last_code = CMD_CLEAR;
            assign last_long = 1'b1;
        end else begin : g_addr
            assign last_code = CMD_SET_ADDR;
            assign last_long = 1'b0;
        end
    endgenerate

    // Select the byte for the requested step.
    always_comb begin
        long_wait = 1'b0;
        if (int'(step) < FSET_REPEAT) begin
            code = CMD_FUNC_8B2L;
        end else if (int'(step) == FSET_REPEAT) begin
            code = CMD_DISP_ON;
        end else if (int'(step) == FSET_REPEAT + 1) begin
            code = CMD_ENTRY_INC;
        end else begin
            code      = last_code;
            long_wait = last_long;
        end
    end

endmodule

// File: rtl/charlcd_step_timer.sv
// Step timer: counts the cycles of one bus write step and shapes the enable
// strobe. A step is a bus cycle of SHORT_CYC followed by a wait of SHORT_CYC or
// LONG_CYC. E is high in phases 1..ceil(SHORT_CYC/2). Assumes SHORT_CYC >= 3.
module charlcd_step_timer #(
    parameter int SHORT_CYC = 56,
    parameter int LONG_CYC  = 2280
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic long_wait,
    output logic e_out,
    output logic step_end
);

    localparam int LEN_S   = 2 * SHORT_CYC;
    localparam int LEN_L   = SHORT_CYC + LONG_CYC;
    localparam int E_HI    = (SHORT_CYC + 1) / 2;
    localparam int PH_W    = $clog2(LEN_L + 1);

    logic [PH_W-1:0] ph;

    assign step_end = run && (ph == (long_wait ? PH_W'(LEN_L - 1) : PH_W'(LEN_S - 1)));

    // Advance the phase and register the strobe for the coming phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph    <= '0;
            e_out <= 1'b0;
        end else if (step_end) begin
            ph    <= '0;
            e_out <= 1'b0;
        end else begin
            ph    <= ph + 1'b1;
            e_out <= (ph + 1'b1) <= PH_W'(E_HI);
        end
    end

endmodule

// File: rtl/charlcd_sequencer.sv
// Top: power-on wait, init program, then endless refresh of the display from a
// character buffer. Never reads the LCD; all pacing comes from fixed cycle
// counts. Assumes the buffer answers chr_addr combinationally.
module charlcd_sequencer
    import charlcd_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int MARGIN_PCT  = 150,
    parameter int PWRON_US    = 40_000,
    parameter int FSET_REPEAT = 3,
    parameter int USE_CLEAR   = 1,
    parameter int LINES       = 2,
    parameter int COLS        = 16,
    parameter int CHR_AW      = $clog2(LINES * COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic              lcd_e,
    output logic [7:0]        lcd_db,
    output logic [CHR_AW-1:0] chr_addr,
    input  logic [7:0]        chr_data,
    output logic              init_done
);

    localparam int SHORT_CYC = scaled_cycles(CLK_HZ, SHORT_US, MARGIN_PCT);
    localparam int LONG_CYC  = scaled_cycles(CLK_HZ, LONG_US, MARGIN_PCT);
    localparam int PWR_CYC   = plain_cycles(CLK_HZ, PWRON_US);
    localparam int E_HI_CYC  = (SHORT_CYC + 1) / 2;
    localparam int N_INIT    = FSET_REPEAT + 3;
    localparam int K_W       = $clog2(N_INIT);
    localparam int LINE_W    = (LINES > 1) ? $clog2(LINES) : 1;
    localparam int COL_W     = $clog2(COLS + 1);
    localparam int PWR_W     = $clog2(PWR_CYC + 1);

    seq_st_t           st;
    logic [PWR_W-1:0]  pwr_cnt;
    logic [K_W-1:0]    k, nxt_k;
    logic [LINE_W-1:0] line, nxt_line;
    logic [COL_W-1:0]  col, nxt_col;
    logic              nxt_run;
    logic [7:0]        init_code, nxt_byte;
    logic              init_long, nxt_rs, nxt_long;
    logic              long_q, run_q, step_end;
    int                chr_idx;

    assign lcd_rw = 1'b0;

    // Work out which step follows the current one.
    always_comb begin
        nxt_run  = 1'b0;
        nxt_k    = '0;
        nxt_line = '0;
        nxt_col  = '0;
        case (st)
            ST_INIT: begin
                if (k == K_W'(N_INIT - 1)) nxt_run = 1'b1;
                else                       nxt_k   = k + 1'b1;
            end
            ST_RUN: begin
                nxt_run = 1'b1;
                if (col == COL_W'(COLS)) begin
                    nxt_line = (line == LINE_W'(LINES - 1)) ? '0 : line + 1'b1;
                end else begin
                    nxt_line = line;
                    nxt_col  = col + 1'b1;
                end
            end
            default: ;
        endcase
    end

    charlcd_init_rom #(
        .FSET_REPEAT (FSET_REPEAT),
        .USE_CLEAR   (USE_CLEAR),
        .K_W         (K_W)
    ) u_rom (
        .step      (nxt_k),
        .code      (init_code),
        .long_wait (init_long)
    );

    // Build the byte, RS level and wait kind of the next step; drive the buffer index.
    always_comb begin
        chr_idx  = int'(nxt_line) * COLS + int'(nxt_col) - 1;
        chr_addr = '0;
        if (!nxt_run) begin
            nxt_byte = init_code;
            nxt_rs   = 1'b0;
            nxt_long = init_long;
        end else if (nxt_col == '0) begin
            nxt_byte = CMD_SET_ADDR | {1'b0, line_base(int'(nxt_line))};
            nxt_rs   = 1'b0;
            nxt_long = 1'b0;
        end else begin
            chr_addr = CHR_AW'(chr_idx);
            nxt_byte = chr_data;
            nxt_rs   = 1'b1;
            nxt_long = 1'b0;
        end
    end

    charlcd_step_timer #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .long_wait (long_q),
        .e_out     (lcd_e),
        .step_end  (step_end)
    );

    // Sequence control: power-on count, then load each step's bus values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_POWER;
            pwr_cnt   <= '0;
            k         <= '0;
            line      <= '0;
            col       <= '0;
            lcd_rs    <= 1'b0;
            lcd_db    <= '0;
            long_q    <= 1'b0;
            run_q     <= 1'b0;
            init_done <= 1'b0;
        end else if (st == ST_POWER) begin
            if (pwr_cnt == PWR_W'(PWR_CYC - 1)) begin
                st     <= ST_INIT;
                run_q  <= 1'b1;
                lcd_rs <= nxt_rs;
                lcd_db <= nxt_byte;
                long_q <= nxt_long;
                k      <= nxt_k;
            end else begin
                pwr_cnt <= pwr_cnt + 1'b1;
            end
        end else if (step_end) begin
            lcd_rs <= nxt_rs;
            lcd_db <= nxt_byte;
            long_q <= nxt_long;
            k      <= nxt_k;
            line   <= nxt_line;
            col    <= nxt_col;
            if (nxt_run) begin
                st        <= ST_RUN;
                init_done <= 1'b1;
            end
        end
    end

    // Keep the cycle-count figure visible to the bound checker.
    localparam int CHK_E_MIN = E_HI_CYC;

endmodule

// File: rtl/charlcd_checker.sv
// Checker: bus-protocol properties of the sequencer, observed at its ports.
// Assumes E_MIN is the required strobe width in cycles.
module charlcd_checker #(
    parameter int E_MIN = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       lcd_rs,
    input logic       lcd_e,
    input logic [7:0] lcd_db,
    input logic       init_done
);

    int hi_cnt;

    // Count consecutive cycles with the strobe high.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_cnt <= 0;
        else if (lcd_e) hi_cnt <= hi_cnt + 1;
        else            hi_cnt <= 0;
    end

    AST_BUS_STABLE_AROUND_E: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e || $fell(lcd_e)) |-> ($stable(lcd_rs) && $stable(lcd_db))); // R6

    AST_E_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> (hi_cnt >= E_MIN)); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R7

    AST_DONE_RISES_E_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> !lcd_e); // R7

    AST_DONE_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |=> lcd_e); // R7

endmodule

bind charlcd_sequencer charlcd_checker #(.E_MIN(CHK_E_MIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lcd_rs    (lcd_rs),
    .lcd_e     (lcd_e),
    .lcd_db    (lcd_db),
    .init_done (init_done)
);

// File: tb/charlcd_sequencer_bench.sv
// Bus probe: records every write seen on the LCD pins, sampled on falling clock edges.
module charlcd_bus_probe (
    input logic       clk,
    input logic       rst_n,
    input logic       e,
    input logic       rs,
    input logic [7:0] db,
    input logic       done
);
    int         rel_cyc = 0;
    int         n = 0;
    int         done_cyc = -1;
    int         glitches = 0;
    int         hi = 0;
    logic       prev_e = 1'b0;
    logic       prev_done = 1'b0;
    logic       cur_rs = 1'b0;
    logic [7:0] cur_db = 8'h00;
    int         rise_cyc [96];
    int         width    [96];
    logic [8:0] wr       [96];
    logic       done_at  [96];

    // Track strobe edges, data stability and the completion flag.
    always @(negedge clk) begin
        if (rst_n) rel_cyc = rel_cyc + 1;
        if (e && !prev_e) begin
            cur_rs = rs;
            cur_db = db;
            hi = 1;
            if (n < 96) begin
                rise_cyc[n] = rel_cyc;
                wr[n] = {rs, db};
                done_at[n] = done;
            end
        end else if (e && prev_e) begin
            hi = hi + 1;
            if (rs !== cur_rs || db !== cur_db) glitches = glitches + 1;
        end else if (!e && prev_e) begin
            if (rs !== cur_rs || db !== cur_db) glitches = glitches + 1;
            if (n < 96) width[n] = hi;
            n = n + 1;
        end
        if (done && !prev_done) done_cyc = rel_cyc;
        prev_e = e;
        prev_done = done;
    end
endmodule

// Bench: two configurations, directed scenario tasks, self-counting checks.
module charlcd_sequencer_bench;

    localparam int A_FS = 3, A_UC = 1, A_COLS = 16, A_LINES = 2, A_S = 56, A_L = 2280, A_PWR = 100;
    localparam int B_FS = 4, B_UC = 0, B_COLS = 8,  B_LINES = 2, B_S = 37, B_L = 1520, B_PWR = 50;
    localparam int A_N = A_FS + 3 + 2 * A_LINES * (A_COLS + 1);
    localparam int B_N = B_FS + 3 + 2 * B_LINES * (B_COLS + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    logic       a_rs, a_rw, a_e, a_done, b_rs, b_rw, b_e, b_done;
    logic [7:0] a_db, b_db, a_chr, b_chr;
    logic [4:0] a_addr;
    logic [3:0] b_addr;

    assign a_chr = 8'h41 + 8'(a_addr);
    assign b_chr = 8'h61 + 8'(b_addr);

    charlcd_sequencer #(
        .CLK_HZ(1_000_000), .MARGIN_PCT(150), .PWRON_US(100), .FSET_REPEAT(A_FS),
        .USE_CLEAR(A_UC), .LINES(A_LINES), .COLS(A_COLS)
    ) u_charlcd_sequencer (
        .clk(clk), .rst_n(rst_n), .lcd_rs(a_rs), .lcd_rw(a_rw), .lcd_e(a_e),
        .lcd_db(a_db), .chr_addr(a_addr), .chr_data(a_chr), .init_done(a_done)
    );

    charlcd_sequencer #(
        .CLK_HZ(1_000_000), .MARGIN_PCT(100), .PWRON_US(50), .FSET_REPEAT(B_FS),
        .USE_CLEAR(B_UC), .LINES(B_LINES), .COLS(B_COLS)
    ) u_charlcd_sequencer_b (
        .clk(clk), .rst_n(rst_n), .lcd_rs(b_rs), .lcd_rw(b_rw), .lcd_e(b_e),
        .lcd_db(b_db), .chr_addr(b_addr), .chr_data(b_chr), .init_done(b_done)
    );

    charlcd_bus_probe u_pa (.clk(clk), .rst_n(rst_n), .e(a_e), .rs(a_rs), .db(a_db), .done(a_done));
    charlcd_bus_probe u_pb (.clk(clk), .rst_n(rst_n), .e(b_e), .rs(b_rs), .db(b_db), .done(b_done));

    task automatic chk(bit ok, string req, int act, int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected {rs, byte} of write i, from R3, R4 and R8.
    function automatic logic [8:0] exp_wr(int i, int fs, int uc, int cols, int lines, logic [7:0] base);
        int r, ln, cl;
        if (i < fs) return {1'b0, 8'h38};
        if (i == fs) return {1'b0, 8'h0C};
        if (i == fs + 1) return {1'b0, 8'h06};
        if (i == fs + 2) return uc ? {1'b0, 8'h01} : {1'b0, 8'h80};
        r  = (i - fs - 3) % (lines * (cols + 1));
        ln = r / (cols + 1);
        cl = r % (cols + 1);
        if (cl == 0) return {1'b0, (ln == 1) ? 8'hC0 : 8'h80};
        return {1'b1, base + 8'(ln * cols + cl - 1)};
    endfunction

    // R1: outputs while reset is held.
    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk(a_e === 0 && a_rs === 0 && a_db === 0 && a_done === 0, "R1 A reset", {a_e, a_rs, a_done, a_db}, 0);
        chk(b_e === 0 && b_rs === 0 && b_db === 0 && b_done === 0, "R1 B reset", {b_e, b_rs, b_done, b_db}, 0);
        chk(a_rw === 0 && b_rw === 0, "R1 rw", {a_rw, b_rw}, 0);
        @(posedge clk);
        #3 rst_n = 1'b1;
    endtask

    // R2: power-on quiet time.
    task automatic t_poweron();
        wait (u_pa.n >= 1 && u_pb.n >= 1);
        chk(u_pa.rise_cyc[0] >= A_PWR && u_pa.rise_cyc[0] <= A_PWR + 2, "R2 A", u_pa.rise_cyc[0], A_PWR);
        chk(u_pb.rise_cyc[0] >= B_PWR && u_pb.rise_cyc[0] <= B_PWR + 2, "R2 B", u_pb.rise_cyc[0], B_PWR);
    endtask

    // R3, R4: initialization programs of both builds.
    task automatic t_init();
        logic [8:0] e;
        wait (u_pa.n >= A_FS + 3 && u_pb.n >= B_FS + 3);
        for (int i = 0; i < A_FS + 3; i++) begin
            e = exp_wr(i, A_FS, A_UC, A_COLS, A_LINES, 8'h41);
            chk(u_pa.wr[i] === e, "R3 A init write", u_pa.wr[i], e);
        end
        for (int i = 0; i < B_FS + 3; i++) begin
            e = exp_wr(i, B_FS, B_UC, B_COLS, B_LINES, 8'h61);
            chk(u_pb.wr[i] === e, (i == B_FS + 2) ? "R4 B last init" : "R3 B init write", u_pb.wr[i], e);
        end
    endtask

    // R5, R6: step lengths, strobe width and data stability.
    task automatic t_timing();
        int d, exp;
        wait (u_pa.n >= A_N && u_pb.n >= B_N);
        for (int i = 0; i + 1 < A_N; i++) begin
            d = u_pa.rise_cyc[i + 1] - u_pa.rise_cyc[i];
            exp = (u_pa.wr[i] === 9'h001) ? A_S + A_L : 2 * A_S;
            chk(d == exp, "R5 A step length", d, exp);
            chk(u_pa.width[i] == (A_S + 1) / 2, "R6 A E width", u_pa.width[i], (A_S + 1) / 2);
        end
        for (int i = 0; i + 1 < B_N; i++) begin
            d = u_pb.rise_cyc[i + 1] - u_pb.rise_cyc[i];
            chk(d == 2 * B_S, (i == B_FS + 2) ? "R4 B short wait" : "R5 B step length", d, 2 * B_S);
            chk(u_pb.width[i] == (B_S + 1) / 2, "R6 B E width", u_pb.width[i], (B_S + 1) / 2);
        end
        chk(u_pa.glitches == 0, "R6 A bus stable", u_pa.glitches, 0);
        chk(u_pb.glitches == 0, "R6 B bus stable", u_pb.glitches, 0);
    endtask

    // R7: completion flag timing and persistence.
    task automatic t_done();
        for (int i = 0; i < A_N; i++)
            chk(u_pa.done_at[i] === (i >= A_FS + 3), "R7 A done level", u_pa.done_at[i], i >= A_FS + 3);
        chk(u_pa.done_cyc == u_pa.rise_cyc[A_FS + 3] - 1, "R7 A done rise", u_pa.done_cyc, u_pa.rise_cyc[A_FS + 3] - 1);
        chk(u_pb.done_cyc == u_pb.rise_cyc[B_FS + 3] - 1, "R7 B done rise", u_pb.done_cyc, u_pb.rise_cyc[B_FS + 3] - 1);
        chk(a_done === 1 && b_done === 1, "R7 done held", {a_done, b_done}, 3);
    endtask

    // R8, R9: refresh content over two passes.
    task automatic t_refresh();
        logic [8:0] e;
        for (int i = A_FS + 3; i < A_N; i++) begin
            e = exp_wr(i, A_FS, A_UC, A_COLS, A_LINES, 8'h41);
            chk(u_pa.wr[i] === e, (i < A_FS + 3 + 34) ? "R8 A pass 1" : "R9 A pass 2", u_pa.wr[i], e);
        end
        for (int i = B_FS + 3; i < B_N; i++) begin
            e = exp_wr(i, B_FS, B_UC, B_COLS, B_LINES, 8'h61);
            chk(u_pb.wr[i] === e, (i < B_FS + 3 + 18) ? "R8 B pass 1" : "R9 B pass 2", u_pb.wr[i], e);
        end
    endtask

    initial begin
        t_reset();
        t_poweron();
        t_init();
        t_timing();
        t_done();
        t_refresh();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (150_000) @(posedge clk);
        if (!finished) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", u_pa.n, A_N);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule